// File: doc/BRIEF.md
# Page-Buffered Write Load Controller

This block models the write side of a byte-wide nonvolatile memory that is rewritten one 64-byte page at a time. A host drives active-low chip-select and write strobes plus an active-low output enable. The block samples them on the system clock and rejects pulses that are too short. Each accepted strobe loads one byte into an internal page buffer, which records which bytes were loaded. The first accepted byte fixes the page that is being loaded. Bytes within that page may arrive in any order.

Loading has no explicit end command. When no new strobe is accepted within a gap window, the block goes busy for a fixed program period. At the end of that period it erases the whole page and writes the buffer into a behavioural storage array. Bytes that were not loaded are left in the erased state (all ones). Strobes that arrive while the block is busy are ignored. A digital supply-good input blocks every load while it is low, and for a settling window after it rises.

All timing windows are counts of clock cycles, set by parameters. This lets simulation use short values. At the full geometry the address is 15 bits wide; the default is reduced to keep the register-file model small. The array can be read at any time through a combinational read port.

Top module: `pgwr_ctrl`

## Requirements
- R1: Address bits above bit 5 select the page and bits 5..0 select the byte within a 64-byte page. A page commit changes only the 64 locations of that page and leaves every other page unchanged.
- R2: A strobe is active when cs_n=0, we_n=0 and oe_n=1 are all sampled together. It loads a byte only if it stays active for at least GLITCH_CYC consecutive clock samples. A shorter pulse, or a pulse with oe_n=0, changes nothing.
- R3: The byte address is taken from the first active sample of a strobe. The data is taken from the last active sample before the strobe is released.
- R4: The program period starts when no strobe is accepted for GAP_CYC cycles after a load. Measured from the first clock edge that samples a strobe released, busy rises after GAP_CYC+1 edges. A new strobe that qualifies inside the window extends the load phase.
- R5: The first byte loaded into an empty buffer fixes the page. A later strobe whose address lies in another page is dropped.
- R6: Busy stays high for PROG_CYC cycles. When busy falls, every loaded byte of the page holds its data, and every byte that was not loaded reads 8'hFF. If the same byte is loaded twice, the later value is kept.
- R7: While busy is high, strobes change neither the buffer nor the array.
- R8: No load is accepted while supply_ok=0, or during the first PWRUP_CYC cycles after supply_ok rises. After that window, loads are accepted again.
- R9: After reset, busy is 0 and every array location reads 8'hFF.
- R10: rd_data always shows the array content at rd_addr, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication, high when supply is valid |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low; must be high for a load |
| addr | input | ADDR_W | Load address (page and byte index) |
| din | input | 8 | Load data |
| rd_addr | input | ADDR_W | Read address into the array |
| rd_data | output | 8 | Array content at rd_addr |
| busy | output | 1 | High during the internal program period |

## Verification
Most faults in this block show up at the ports as a wrong value in the array after the next commit. Examples are a page lock that has gone stale, a loaded-byte mask that was not cleared, or an address or data byte latched at the wrong sample. Each of these is visible on rd_data in the cycle after busy falls. Faults in the gap or program counters move the busy edge by at least one cycle. A reference model that runs in lockstep therefore catches them at the first clock where busy differs. Faults in filter or power gating make a load appear where none should be, or vanish. These show up as a busy rise that was not expected, or one that is missing, about GAP_CYC cycles after the strobe.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgwr_state_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // Value written to one array byte at commit time.
  function automatic logic [7:0] merge_byte(input logic loaded, input logic [7:0] val);
    return loaded ? val : ERASED_BYTE;
  endfunction

endpackage

// File: rtl/pgwr_pwr_gate.sv
module pgwr_pwr_gate #(
  parameter int PWRUP_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic ready
);
  localparam int CW = $clog2(PWRUP_CYC + 1);
  localparam logic [CW-1:0] C_MAX = CW'(PWRUP_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!supply_ok) cnt_q <= '0;
    else if (cnt_q != C_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign ready = supply_ok && (cnt_q == C_MAX);

  // R8: ready can only come after a full settling window with supply high
  p_ready_needs_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(supply_ok));

endmodule

// File: rtl/pgwr_strobe_filt.sv
module pgwr_strobe_filt #(
  parameter int ADDR_W     = 11,
  parameter int GLITCH_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_on,
  input  logic              permit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              load_ev,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [7:0]        ld_data,
  output logic              held
);
  localparam int RW = $clog2(GLITCH_CYC + 1);
  localparam logic [RW-1:0] R_MAX = RW'(GLITCH_CYC);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      load_ev <= 1'b0;
      ld_addr <= '0;
      ld_data <= '0;
    end else if (strobe_on) begin
      load_ev <= 1'b0;
      if (run_q == '0) ld_addr <= addr;
      ld_data <= din;
      if (run_q != R_MAX) run_q <= run_q + 1'b1;
    end else begin
      load_ev <= (run_q == R_MAX) && permit;
      run_q   <= '0;
    end
  end

  assign held = (run_q == R_MAX);

  // R2: a load event is a single-cycle pulse
  p_ev_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> !load_ev);
  // R2: an event follows a release, never a still-active strobe
  p_ev_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |-> !$past(strobe_on));

endmodule

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
  parameter int ADDR_W = 11,
  parameter int BYTE_W = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load_ev,
  input  logic [ADDR_W-1:0]              ld_addr,
  input  logic [7:0]                     ld_data,
  input  logic                           commit,
  output logic [ADDR_W-BYTE_W-1:0]       page,
  output logic [(1<<BYTE_W)*8-1:0]       page_data,
  output logic                           empty
);
  import pgwr_pkg::*;

  localparam int PAGE_BYTES = 1 << BYTE_W;
  localparam int PG_W       = ADDR_W - BYTE_W;

  logic [PAGE_BYTES-1:0][7:0] buf_q;
  logic [PAGE_BYTES-1:0]      mask_q;
  logic [PG_W-1:0]            page_q;

  function automatic logic [PG_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] byte_of(input logic [ADDR_W-1:0] a);
    return a[BYTE_W-1:0];
  endfunction

  logic take;
  assign empty = (mask_q == '0);
  assign take  = load_ev && (empty || (page_of(ld_addr) == page_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      mask_q <= '0;
      page_q <= '0;
    end else if (commit) begin
      mask_q <= '0;
    end else if (take) begin
      buf_q[byte_of(ld_addr)]  <= ld_data;
      mask_q[byte_of(ld_addr)] <= 1'b1;
      if (empty) page_q <= page_of(ld_addr);
    end
  end

  assign page = page_q;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_merge
    assign page_data[i*8 +: 8] = merge_byte(mask_q[i], buf_q[i]);
  end

  // R6: the loaded mask is empty after every commit
  p_mask_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> empty);
  // R5: the locked page never moves while bytes are pending
  p_page_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !commit) |=> $stable(page_q));

endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq #(
  parameter int GAP_CYC  = 30,
  parameter int PROG_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_ev,
  input  logic held,
  output logic busy,
  output logic commit
);
  import pgwr_pkg::*;

  localparam int GW = $clog2(GAP_CYC + 1);
  localparam int PW = $clog2(PROG_CYC + 1);
  localparam logic [GW-1:0] G_END = GW'(GAP_CYC - 1);
  localparam logic [PW-1:0] P_END = PW'(PROG_CYC - 1);

  pgwr_state_e   st_q;
  logic [GW-1:0] gap_q;
  logic [PW-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      gap_q <= '0;
      pc_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (load_ev) begin
          st_q  <= ST_LOAD;
          gap_q <= '0;
        end
        ST_LOAD: begin
          if (held || load_ev) gap_q <= '0;
          else if (gap_q == G_END) begin
            st_q <= ST_PROG;
            pc_q <= '0;
          end else gap_q <= gap_q + 1'b1;
        end
        ST_PROG: begin
          if (pc_q == P_END) st_q <= ST_IDLE;
          else pc_q <= pc_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (st_q == ST_PROG);
  assign commit = busy && (pc_q == P_END);

  // R4: the gap counter never exceeds its window
  p_gap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD) |-> (gap_q < GW'(GAP_CYC)));
  // R6: busy ends in the cycle after the commit
  p_commit_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
  // R7: no load event is produced while busy
  p_no_load_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load_ev);

endmodule

// File: rtl/pgwr_store.sv
module pgwr_store #(
  parameter int ADDR_W = 11,
  parameter int BYTE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [ADDR_W-BYTE_W-1:0] page,
  input  logic [(1<<BYTE_W)*8-1:0] page_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data
);
  import pgwr_pkg::*;

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << BYTE_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED_BYTE;
    end else if (commit) begin
      for (int j = 0; j < PAGE_BYTES; j++)
        mem_q[{page, BYTE_W'(j)}] <= page_data[j*8 +: 8];
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R1: a location outside the committed page keeps its value
  p_other_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (rd_addr[ADDR_W-1:BYTE_W] != page)) |=> $stable(rd_data) || !$stable(rd_addr));

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
  parameter int ADDR_W     = 11,
  parameter int GLITCH_CYC = 3,
  parameter int GAP_CYC    = 30,
  parameter int PROG_CYC   = 50,
  parameter int PWRUP_CYC  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);
  localparam int BYTE_W     = 6;
  localparam int PAGE_BYTES = 1 << BYTE_W;
  localparam int PG_W       = ADDR_W - BYTE_W;

  logic                    ready;
  logic                    permit;
  logic                    strobe_on;
  logic                    load_ev;
  logic                    held;
  logic [ADDR_W-1:0]       ld_addr;
  logic [7:0]              ld_data;
  logic                    commit;
  logic [PG_W-1:0]         page;
  logic [PAGE_BYTES*8-1:0] page_data;
  logic                    buf_empty;

  assign permit    = ready && !busy;
  assign strobe_on = !cs_n && !we_n && oe_n && permit;

  pgwr_pwr_gate #(.PWRUP_CYC(PWRUP_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ready(ready)
  );

  pgwr_strobe_filt #(.ADDR_W(ADDR_W), .GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .strobe_on(strobe_on), .permit(permit),
    .addr(addr), .din(din), .load_ev(load_ev), .ld_addr(ld_addr),
    .ld_data(ld_data), .held(held)
  );

  pgwr_page_buf #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .ld_addr(ld_addr),
    .ld_data(ld_data), .commit(commit), .page(page),
    .page_data(page_data), .empty(buf_empty)
  );

  pgwr_seq #(.GAP_CYC(GAP_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .held(held),
    .busy(busy), .commit(commit)
  );

  pgwr_store #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .page(page),
    .page_data(page_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R8: every accepted load happened with the supply good
  p_load_needs_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |-> $past(supply_ok));
  // R6: the buffer holds data whenever a commit fires
  p_commit_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !buf_empty);

endmodule

// File: tb/pgwr_ctrl_tb_top.sv
module pgwr_ctrl_tb_top;
  localparam int ADDR_W = 11;
  localparam int GLITCH = 3;
  localparam int GAP    = 30;
  localparam int PROG   = 50;
  localparam int PWRUP  = 20;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0, rd_addr = '0;
  logic [7:0] din = '0;
  logic [7:0] rd_data;
  logic busy;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  pgwr_ctrl #(.ADDR_W(ADDR_W), .GLITCH_CYC(GLITCH), .GAP_CYC(GAP),
              .PROG_CYC(PROG), .PWRUP_CYC(PWRUP)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] m_mem [DEPTH];
  logic [7:0] m_pend [int];   // byte index -> data, loaded bytes only
  int m_pw, m_run, m_addr, m_din, m_phase, m_gap, m_pc, m_page;
  bit m_ev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
      m_pend.delete();
      m_pw = 0; m_run = 0; m_addr = 0; m_din = 0;
      m_phase = 0; m_gap = 0; m_pc = 0; m_page = 0; m_ev = 0;
    end else begin
      bit rdy, bsy, hold, act, ev;
      rdy  = supply_ok && (m_pw == PWRUP);
      bsy  = (m_phase == 2);
      hold = (m_run == GLITCH);
      ev   = m_ev;
      act  = !cs_n && !we_n && oe_n && rdy && !bsy;
      // sequencing and page buffer use the pre-edge state
      if (m_phase == 0) begin
        if (ev) begin m_phase = 1; m_gap = 0; end
      end else if (m_phase == 1) begin
        if (hold || ev) m_gap = 0;
        else if (m_gap == GAP - 1) begin m_phase = 2; m_pc = 0; end
        else m_gap++;
      end else begin
        if (m_pc == PROG - 1) begin
          for (int b = 0; b < 64; b++)
            m_mem[m_page*64 + b] = m_pend.exists(b) ? m_pend[b] : 8'hFF;
          m_pend.delete();
          m_phase = 0;
        end else m_pc++;
      end
      if (ev) begin
        if (m_pend.size() == 0) begin
          m_page = m_addr / 64;
          m_pend[m_addr % 64] = m_din[7:0];
        end else if (m_addr / 64 == m_page) m_pend[m_addr % 64] = m_din[7:0];
      end
      // strobe qualification
      if (act) begin
        if (m_run == 0) m_addr = int'(addr);
        m_din = int'(din);
        if (m_run < GLITCH) m_run++;
        m_ev = 0;
      end else begin
        m_ev = hold && rdy && !bsy;
        m_run = 0;
      end
      if (!supply_ok) m_pw = 0;
      else if (m_pw != PWRUP) m_pw++;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // lockstep compare of every cycle (R6, R10)
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      chk("R6 busy vs model", int'(busy), int'(m_phase == 2));
      chk("R10 rd_data vs model", int'(rd_data), int'(m_mem[rd_addr]));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic strobe(input int a, input int d, input int len);
    @(negedge clk);
    addr = ADDR_W'(a); din = 8'(d); cs_n = 1'b0; we_n = 1'b0;
    repeat (len) @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input string tag, input int a, input int exp);
    @(negedge clk);
    rd_addr = ADDR_W'(a);
    #1;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic settle();
    idle(GAP + PROG + 10);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    #1;
    chk("R9 busy after reset", int'(busy), 0);
    rd("R9 first location erased", 0, 8'hFF);
    rd("R9 last location erased", DEPTH - 1, 8'hFF);

    // R8: loads inside the settling window are dropped
    strobe(128, 8'h11, 4);
    settle();
    rd("R8 load during settling ignored", 128, 8'hFF);

    // R5 R6 R7 R4: out-of-order bytes, foreign page, busy timing
    strobe(192 + 5, 8'hA5, 4); idle(3);
    strobe(192 + 0, 8'h3C, 4); idle(3);
    strobe(192 + 63, 8'h7E, 4); idle(3);
    strobe(256 + 7, 8'h99, 4);
    idle(GAP + 1); #1;
    chk("R4 busy still low at window end", int'(busy), 0);
    @(negedge clk); #1;
    chk("R4 busy rises after gap", int'(busy), 1);
    strobe(192 + 1, 8'h55, 4);   // R7: during busy
    settle();
    rd("R6 loaded byte 5", 197, 8'hA5);
    rd("R6 loaded byte 0", 192, 8'h3C);
    rd("R6 loaded byte 63", 255, 8'h7E);
    rd("R7 strobe while busy ignored", 193, 8'hFF);
    rd("R6 unloaded byte erased", 194, 8'hFF);
    rd("R5 other-page byte dropped", 263, 8'hFF);

    // R2: short pulse and output-enable low
    strobe(384, 8'h42, GLITCH - 1);
    settle();
    rd("R2 short pulse ignored", 384, 8'hFF);
    @(negedge clk); oe_n = 1'b0;
    strobe(385, 8'h43, 4);
    @(negedge clk); oe_n = 1'b1;
    settle();
    rd("R2 oe low blocks load", 385, 8'hFF);

    // R3: address on first active sample, data on last
    @(negedge clk); addr = ADDR_W'(514); din = 8'h10; cs_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); addr = ADDR_W'(520); din = 8'h20;
    @(negedge clk); din = 8'h30;
    @(negedge clk); din = 8'h40;
    @(negedge clk); cs_n = 1'b1; we_n = 1'b1;
    settle();
    rd("R3 data from last sample at first address", 514, 8'h40);
    rd("R3 later address not used", 520, 8'hFF);

    // R4 R6 R1: window extension, last write wins, erase of old data
    strobe(192 + 0, 8'h01, 4); idle(GAP / 2);
    strobe(192 + 10, 8'h02, 4); idle(GAP / 2);
    strobe(192 + 0, 8'h03, 4);
    settle();
    rd("R6 repeated byte keeps later value", 192, 8'h03);
    rd("R4 byte inside extended window", 202, 8'h02);
    rd("R6 previous page content erased", 197, 8'hFF);
    rd("R1 other page untouched", 514, 8'h40);

    // R8: supply low, then fresh rise, then settled
    @(negedge clk); supply_ok = 1'b0;
    strobe(640, 8'h66, 4);
    @(negedge clk); supply_ok = 1'b1;
    strobe(641, 8'h67, 4);
    settle();
    rd("R8 supply low ignored", 640, 8'hFF);
    rd("R8 right after rise ignored", 641, 8'hFF);
    strobe(642, 8'h77, 4);
    settle();
    rd("R8 load accepted after settling", 642, 8'h77);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule